// File: doc/BRIEF.md
# UART Interrupt Priority Encoder

This block reduces the interrupt sources of a 16550-style serial port to one interrupt line and one identification byte. It holds the 4-bit interrupt-enable register. It keeps the sticky break and overrun flags and the transmit-empty pending flag. From these and the live inputs it picks the highest-ranked source that is both asserted and enabled. The line-status error, receive timeout, data available, transmit empty and modem-status change sources are all combined here. The FIFOs and the serial shifters stay outside. They supply levels and pulses: data-ready, FIFO occupancy, trigger level, timeout pending, holding-register empty, error level and modem deltas.

A register front end feeds it single-cycle strobes for writes to the enable register and the transmit holding register, and for reads of the identification and line-status registers. Every effect of a strobe or input change shows on the registered outputs after one clock edge. A strobe's effects on the pending state and on the identification byte appear at the same edge.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After a synchronous reset, `iir_o` is 8'h01, `irq_o` is 0, `ier_o` is 0 and both sticky flags are 0.
- R2: An enable-register write stores only `wdata_i[3:0]` into `ier_o`. The enable bits are: bit 0 receive data (also masks the timeout), bit 1 transmit empty, bit 2 line status, bit 3 modem status.
- R3: Sources are ranked from high to low as follows, each with its code in `iir_o[3:0]`: line error (enable bit 2) 4'h6, receive timeout 4'hC, data available 4'h4, transmit empty (enable bit 1) 4'h2, modem change (enable bit 3) 4'h0. With no source, the code is 4'h1. A line error is the break flag, the overrun flag or `err_lvl_i`. A modem change is any bit of `msr_delta_i`.
- R4: The receive timeout source is gated by enable bit 0 and has no enable of its own.
- R5: When `fifo_en_i` is 1, data available requires `rx_ready_i` and `rx_count_i >= rx_trig_i`. When `fifo_en_i` is 0, it equals `rx_ready_i`.
- R6: `iir_o[7:6]` are 2'b11 when `fifo_en_i` is 1 and 2'b00 otherwise. `iir_o[5:4]` are 0.
- R7: A transmit-holding write clears the transmit-empty pending flag. This has priority over every other event in the same cycle.
- R8: An enable-register write sets the transmit-empty pending flag to (`wdata_i[1]` AND `thr_empty_i`).
- R9: A rising edge of `thr_empty_i`, with no register write in the same cycle, sets the transmit-empty pending flag.
- R10: An identification read clears the transmit-empty pending flag only when `iir_o[3:0]` showed 4'h2 at that read.
- R11: A line-status read clears the break and overrun flags. A set pulse in the same cycle wins.
- R12: `irq_o` is 1 exactly when `iir_o[3:0]` is not 4'h1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ier_wr_i | input | 1 | Enable-register write strobe |
| wdata_i | input | 8 | Write data |
| thr_wr_i | input | 1 | Transmit-holding write strobe |
| iir_rd_i | input | 1 | Identification read strobe |
| lsr_rd_i | input | 1 | Line-status read strobe |
| fifo_en_i | input | 1 | FIFO mode on |
| rx_ready_i | input | 1 | Receive data ready |
| rx_count_i | input | 5 | Receive FIFO occupancy |
| rx_trig_i | input | 5 | Receive trigger level |
| rx_timeout_i | input | 1 | Receive timeout pending |
| thr_empty_i | input | 1 | Transmit holding register empty |
| err_lvl_i | input | 1 | Parity or framing error level |
| brk_set_i | input | 1 | Break detected pulse |
| ovr_set_i | input | 1 | Overrun pulse |
| msr_delta_i | input | 4 | Modem-status delta bits |
| ier_o | output | 4 | Enable register |
| brk_flag_o | output | 1 | Sticky break flag |
| ovr_flag_o | output | 1 | Sticky overrun flag |
| iir_o | output | 8 | Identification byte |
| irq_o | output | 1 | Interrupt line |

## Verification
The encoder is swept over all 16 enable values and all 32 combinations of the five raw sources, in both FIFO modes. Each combination is tried with occupancy just below and exactly at the trigger level. These sweeps separate the priority ranking, the masking of the timeout by the receive enable, the trigger gating and the upper identification bits. Directed sequences cover the transmit-empty pending flag: write, enable write, rising empty edge, and reads that show and that hide the flag. Further sequences cover sticky-flag clearing, including a set pulse that collides with the read.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  typedef enum logic [3:0] {
    ID_MODEM  = 4'h0,
    ID_NONE   = 4'h1,
    ID_TXE    = 4'h2,
    ID_RXDATA = 4'h4,
    ID_LINE   = 4'h6,
    ID_TMO    = 4'hC
  } irq_id_e;

  localparam int NUM_SRC = 5;

  // index 0 is the highest rank
  function automatic irq_id_e src_id(input int idx);
    case (idx)
      0:       return ID_LINE;
      1:       return ID_TMO;
      2:       return ID_RXDATA;
      3:       return ID_TXE;
      4:       return ID_MODEM;
      default: return ID_NONE;
    endcase
  endfunction

  function automatic irq_id_e pick_src(input logic [NUM_SRC-1:0] req);
    irq_id_e id;
    id = ID_NONE;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req[i]) id = src_id(i);
    end
    return id;
  endfunction

endpackage

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
  parameter int DATA_W = 8,
  parameter int IER_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [IER_W-1:0]  ier_nxt_o,
  output logic [IER_W-1:0]  ier_q_o
);
  logic unused_hi;
  assign unused_hi = ^wdata_i[DATA_W-1:IER_W];

  always_comb begin
    ier_nxt_o = ier_q_o;
    if (wr_i) ier_nxt_o = wdata_i[IER_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) ier_q_o <= '0;
    else     ier_q_o <= ier_nxt_o;
  end

  // R2: only the low nibble is kept
  a_r2_ier_store: assert property (@(posedge clk) disable iff (rst)
    wr_i |=> ier_q_o == $past(wdata_i[IER_W-1:0]));
endmodule

// File: rtl/irq_sticky_flags.sv
module irq_sticky_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] flag_nxt_o,
  output logic [N-1:0] flag_q_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    assign flag_nxt_o[g] = (flag_q_o[g] & ~clr_i) | set_i[g];

    always_ff @(posedge clk) begin
      if (rst) flag_q_o[g] <= 1'b0;
      else     flag_q_o[g] <= flag_nxt_o[g];
    end

    // R11: a read without a colliding set leaves the flag clear
    a_r11_read_clears: assert property (@(posedge clk) disable iff (rst)
      (clr_i && !set_i[g]) |=> !flag_q_o[g]);
    a_r11_set_wins: assert property (@(posedge clk) disable iff (rst)
      set_i[g] |=> flag_q_o[g]);
  end
endmodule

// File: rtl/irq_txe_pending.sv
module irq_txe_pending (
  input  logic clk,
  input  logic rst,
  input  logic thr_wr_i,
  input  logic ier_wr_i,
  input  logic ier_txe_i,
  input  logic thr_empty_i,
  input  logic iir_rd_i,
  input  logic txe_shown_i,
  output logic pend_nxt_o
);
  logic pend_q;
  logic empty_q;
  logic empty_rise;

  assign empty_rise = thr_empty_i & ~empty_q;

  always_comb begin
    pend_nxt_o = pend_q;
    if (thr_wr_i)                     pend_nxt_o = 1'b0;
    else if (ier_wr_i)                pend_nxt_o = ier_txe_i & thr_empty_i;
    else if (empty_rise)              pend_nxt_o = 1'b1;
    else if (iir_rd_i && txe_shown_i) pend_nxt_o = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= 1'b0;
      empty_q <= 1'b1;
    end else begin
      pend_q  <= pend_nxt_o;
      empty_q <= thr_empty_i;
    end
  end

  // R7: a holding write always leaves the flag clear
  a_r7_write_clears: assert property (@(posedge clk) disable iff (rst)
    thr_wr_i |=> !pend_q);
  // R10: a read that did not show the flag leaves it untouched
  a_r10_hidden_read: assert property (@(posedge clk) disable iff (rst)
    (iir_rd_i && !txe_shown_i && !thr_wr_i && !ier_wr_i && !empty_rise) |=>
    pend_q == $past(pend_q));
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import uart_irq_pkg::*;
#(
  parameter int CNT_W   = 5,
  parameter int IER_W   = 4,
  parameter int DELTA_W = 4
) (
  input  logic [IER_W-1:0]   ier_i,
  input  logic               line_err_i,
  input  logic               timeout_i,
  input  logic               rx_ready_i,
  input  logic               fifo_en_i,
  input  logic [CNT_W-1:0]   rx_count_i,
  input  logic [CNT_W-1:0]   rx_trig_i,
  input  logic               txe_pend_i,
  input  logic [DELTA_W-1:0] delta_i,
  output irq_id_e            id_o
);
  logic               data_avail;
  logic [NUM_SRC-1:0] req;

  assign data_avail = fifo_en_i ? (rx_ready_i && (rx_count_i >= rx_trig_i)) : rx_ready_i;

  assign req[0] = ier_i[2] & line_err_i;
  assign req[1] = ier_i[0] & timeout_i;
  assign req[2] = ier_i[0] & data_avail;
  assign req[3] = ier_i[1] & txe_pend_i;
  assign req[4] = ier_i[3] & (|delta_i);

  assign id_o = pick_src(req);

  always_comb begin
    // R4: a reported timeout implies the receive enable
    if (id_o == ID_TMO) begin
      a_r4_tmo_masked: assert (ier_i[0] && timeout_i);
    end
    // R3: a reported line error outranks everything
    if (ier_i[2] && line_err_i) begin
      a_r3_line_first: assert (id_o == ID_LINE);
    end
  end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int DATA_W     = 8,
  parameter int IER_W      = 4,
  parameter int DELTA_W    = 4,
  localparam int CNT_W     = $clog2(FIFO_DEPTH) + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ier_wr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               thr_wr_i,
  input  logic               iir_rd_i,
  input  logic               lsr_rd_i,
  input  logic               fifo_en_i,
  input  logic               rx_ready_i,
  input  logic [CNT_W-1:0]   rx_count_i,
  input  logic [CNT_W-1:0]   rx_trig_i,
  input  logic               rx_timeout_i,
  input  logic               thr_empty_i,
  input  logic               err_lvl_i,
  input  logic               brk_set_i,
  input  logic               ovr_set_i,
  input  logic [DELTA_W-1:0] msr_delta_i,
  output logic [IER_W-1:0]   ier_o,
  output logic               brk_flag_o,
  output logic               ovr_flag_o,
  output logic [DATA_W-1:0]  iir_o,
  output logic               irq_o
);
  localparam int N_STICKY = 2;

  logic [IER_W-1:0]    ier_nxt;
  logic [N_STICKY-1:0] flag_nxt, flag_q;
  logic                pend_nxt;
  logic                txe_shown;
  irq_id_e             id_nxt;
  logic [DATA_W-1:0]   iir_q;
  logic                irq_q;

  irq_enable_reg #(.DATA_W(DATA_W), .IER_W(IER_W)) i_ier (
    .clk(clk), .rst(rst), .wr_i(ier_wr_i), .wdata_i(wdata_i),
    .ier_nxt_o(ier_nxt), .ier_q_o(ier_o));

  irq_sticky_flags #(.N(N_STICKY)) i_flags (
    .clk(clk), .rst(rst), .set_i({ovr_set_i, brk_set_i}), .clr_i(lsr_rd_i),
    .flag_nxt_o(flag_nxt), .flag_q_o(flag_q));

  assign txe_shown = (iir_q[3:0] == ID_TXE);

  irq_txe_pending i_txe (
    .clk(clk), .rst(rst), .thr_wr_i(thr_wr_i), .ier_wr_i(ier_wr_i),
    .ier_txe_i(wdata_i[1]), .thr_empty_i(thr_empty_i), .iir_rd_i(iir_rd_i),
    .txe_shown_i(txe_shown), .pend_nxt_o(pend_nxt));

  irq_prio_enc #(.CNT_W(CNT_W), .IER_W(IER_W), .DELTA_W(DELTA_W)) i_enc (
    .ier_i(ier_nxt), .line_err_i((|flag_nxt) | err_lvl_i), .timeout_i(rx_timeout_i),
    .rx_ready_i(rx_ready_i), .fifo_en_i(fifo_en_i), .rx_count_i(rx_count_i),
    .rx_trig_i(rx_trig_i), .txe_pend_i(pend_nxt), .delta_i(msr_delta_i),
    .id_o(id_nxt));

  always_ff @(posedge clk) begin
    if (rst) begin
      iir_q <= {{(DATA_W-4){1'b0}}, ID_NONE};
      irq_q <= 1'b0;
    end else begin
      iir_q <= {{2{fifo_en_i}}, {(DATA_W-6){1'b0}}, id_nxt};
      irq_q <= (id_nxt != ID_NONE);
    end
  end

  assign iir_o      = iir_q;
  assign irq_o      = irq_q;
  assign brk_flag_o = flag_q[0];
  assign ovr_flag_o = flag_q[1];

  // R1: reset leaves the block idle
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (iir_o == 8'h01 && !irq_o && ier_o == '0 && !brk_flag_o && !ovr_flag_o));
  // R7: a holding write never leaves the transmit code reported
  a_r7_no_txe_after_write: assert property (@(posedge clk) disable iff (rst)
    thr_wr_i |=> iir_o[3:0] != ID_TXE);
  // R6: FIFO-mode bits follow the mode input
  a_r6_upper_bits: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> iir_o[7:4] == {{2{$past(fifo_en_i)}}, 2'b00});
endmodule

// File: tb/test_uart_irq_ctrl.sv
module test_uart_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst;
  logic       ier_wr_i, thr_wr_i, iir_rd_i, lsr_rd_i;
  logic [7:0] wdata_i;
  logic       fifo_en_i, rx_ready_i, rx_timeout_i, thr_empty_i, err_lvl_i;
  logic       brk_set_i, ovr_set_i;
  logic [4:0] rx_count_i, rx_trig_i;
  logic [3:0] msr_delta_i;
  logic [3:0] ier_o;
  logic       brk_flag_o, ovr_flag_o, irq_o;
  logic [7:0] iir_o;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  uart_irq_ctrl i_uart_irq_ctrl (
    .clk(clk), .rst(rst), .ier_wr_i(ier_wr_i), .wdata_i(wdata_i),
    .thr_wr_i(thr_wr_i), .iir_rd_i(iir_rd_i), .lsr_rd_i(lsr_rd_i),
    .fifo_en_i(fifo_en_i), .rx_ready_i(rx_ready_i), .rx_count_i(rx_count_i),
    .rx_trig_i(rx_trig_i), .rx_timeout_i(rx_timeout_i), .thr_empty_i(thr_empty_i),
    .err_lvl_i(err_lvl_i), .brk_set_i(brk_set_i), .ovr_set_i(ovr_set_i),
    .msr_delta_i(msr_delta_i), .ier_o(ier_o), .brk_flag_o(brk_flag_o),
    .ovr_flag_o(ovr_flag_o), .iir_o(iir_o), .irq_o(irq_o));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // expected {irq, iir} from the ranking rules
  function automatic logic [8:0] model(input logic [3:0] ier, input logic err,
      input logic tmo, input logic dr, input logic ge, input logic fifo,
      input logic pend, input logic dlt);
    logic [3:0] c;
    if (ier[2] && err)                     c = 4'h6;
    else if (ier[0] && tmo)                c = 4'hC;
    else if (ier[0] && dr && (!fifo || ge)) c = 4'h4;
    else if (ier[1] && pend)               c = 4'h2;
    else if (ier[3] && dlt)                c = 4'h0;
    else                                   c = 4'h1;
    return {c != 4'h1, fifo, fifo, 2'b00, c};
  endfunction

  task automatic idle_inputs();
    ier_wr_i = 0; thr_wr_i = 0; iir_rd_i = 0; lsr_rd_i = 0; wdata_i = 0;
    fifo_en_i = 0; rx_ready_i = 0; rx_timeout_i = 0; thr_empty_i = 0;
    err_lvl_i = 0; brk_set_i = 0; ovr_set_i = 0; rx_count_i = 0;
    rx_trig_i = 1; msr_delta_i = 0;
  endtask

  task automatic do_reset();
    rst = 1; step(); step(); rst = 0;
  endtask

  initial begin
    idle_inputs();
    do_reset();
    // R1
    chk("R1 iir", iir_o, 8'h01);
    chk("R1 irq", irq_o, 0);
    chk("R1 ier", ier_o, 0);
    chk("R1 flags", {brk_flag_o, ovr_flag_o}, 0);

    // sweep: R3 R4 R5 R6 R8 R12
    for (int f = 0; f < 2; f++) begin
      for (int ge = 0; ge < 2; ge++) begin
        for (int ie = 0; ie < 16; ie++) begin
          for (int s = 0; s < 32; s++) begin
            logic [4:0] trig;
            logic [4:0] src;
            src  = s[4:0];
            case (ie % 4)
              0: trig = 5'd1;
              1: trig = 5'd4;
              2: trig = 5'd8;
              default: trig = 5'd14;
            endcase
            ier_wr_i = 1; wdata_i = {4'hA, ie[3:0]};
            fifo_en_i = f[0]; err_lvl_i = src[0]; rx_timeout_i = src[1];
            rx_ready_i = src[2]; thr_empty_i = src[3]; msr_delta_i = {src[4], 3'b000};
            rx_trig_i = trig; rx_count_i = ge[0] ? trig : trig - 5'd1;
            step();
            chk("R3 R4 R5 R6 R8 R12 sweep", {irq_o, iir_o},
                model(ie[3:0], src[0], src[1], src[2], ge[0], f[0],
                      src[3] & ie[1], src[4]));
          end
        end
      end
    end

    idle_inputs();
    do_reset();
    // R2 and R8 with holding register full
    ier_wr_i = 1; wdata_i = 8'hFF; step(); ier_wr_i = 0;
    chk("R2 ier", ier_o, 4'hF);
    chk("R8 no pend", iir_o, 8'h01);
    // R9 rising empty
    thr_empty_i = 1; step();
    chk("R9 iir", iir_o, 8'h02);
    chk("R12 irq", irq_o, 1);
    // R7
    thr_wr_i = 1; step(); thr_wr_i = 0;
    chk("R7 iir", iir_o, 8'h01);
    chk("R7 irq", irq_o, 0);
    // R8 set
    ier_wr_i = 1; wdata_i = 8'h02; step(); ier_wr_i = 0;
    chk("R8 pend", iir_o, 8'h02);
    // R10 hidden read
    ier_wr_i = 1; wdata_i = 8'h06; err_lvl_i = 1; step(); ier_wr_i = 0;
    chk("R3 line over txe", iir_o, 8'h06);
    iir_rd_i = 1; step(); iir_rd_i = 0; err_lvl_i = 0; step();
    chk("R10 hidden kept", iir_o, 8'h02);
    iir_rd_i = 1; step(); iir_rd_i = 0;
    chk("R10 shown cleared", iir_o, 8'h01);
    step();
    chk("R10 stays clear", iir_o, 8'h01);
    // R11
    brk_set_i = 1; step(); brk_set_i = 0;
    chk("R11 brk set", brk_flag_o, 1);
    chk("R11 brk iir", iir_o, 8'h06);
    lsr_rd_i = 1; step(); lsr_rd_i = 0;
    chk("R11 brk clr", brk_flag_o, 0);
    chk("R11 iir clr", iir_o, 8'h01);
    ovr_set_i = 1; lsr_rd_i = 1; step(); ovr_set_i = 0;
    chk("R11 set wins", ovr_flag_o, 1);
    step(); lsr_rd_i = 0;
    chk("R11 ovr clr", ovr_flag_o, 0);
    // R1 mid-run
    ier_wr_i = 1; wdata_i = 8'h04; err_lvl_i = 1; step(); ier_wr_i = 0;
    chk("R1 pre", irq_o, 1);
    rst = 1; step(); rst = 0;
    chk("R1 mid iir", iir_o, 8'h01);
    chk("R1 mid ier", ier_o, 0);
    done = 1;
  end

  initial begin
    for (int n = 0; n < 100000; n++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule